// File: doc/BRIEF.md
# Once-a-Second Decimal Digit Flasher

This block drives one seven-segment digit through the decimal values 0 to 9 in ascending order, one step per second, and wraps from 9 back to 0 indefinitely. All storage runs on a single free-running system clock, 50 MHz by default. The one-second interval comes from a prescaler counter that runs on every clock cycle and produces a one-cycle enable pulse. It is never a divided or gated clock.

A mod-10 digit register advances only in the cycle that carries the enable pulse. A combinational decoder turns the digit into an active-low segment pattern. The prescaler length `TICKS` is a parameter, so a short interval can be used in simulation. A synchronous active-high reset restarts both the prescaler and the digit.

Top module: `sec_digit_flasher`

## Requirements
- R1: While `rst` is high at a rising edge, the prescaler and the digit clear to 0. From the next edge on, `seg_n` shows the pattern for 0 (7'b1000000).
- R2: After `rst` is released, digit 0 stays on `seg_n` for exactly `TICKS` rising edges. It changes to 1 on the `TICKS`-th edge.
- R3: Every later digit is held for exactly `TICKS` rising edges, so the step pulse occurs once every `TICKS` cycles.
- R4: Each step raises the digit by one, giving the order 0, 1, 2, … 9.
- R5: The step after digit 9 produces digit 0, and the sequence then repeats.
- R6: `seg_n` is active-low. Bit 6 is segment g and bit 0 is segment a, in the order {g,f,e,d,c,b,a}, with a lit segment driven to 0. The patterns for digits 0 to 9 are 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000.
- R7: A reset applied partway through the sequence returns the display to 0. After release, that 0 is again held for a full `TICKS` edges.
- R8: The digit never exceeds 9, and the prescaler never exceeds `TICKS`-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock; every flip-flop uses it |
| rst | input | 1 | Synchronous active-high reset |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |

## Verification
The assertions assume that `rst` is held high from time zero through at least one rising edge and is sampled only at rising edges. They also assume that `TICKS` is at least 1, so that a terminal count exists. The bench drives `rst` only on falling edges and keeps it asserted for several cycles at start-up. It overrides `TICKS` with 5, so that two full wraps of the sequence and a reset in mid-sequence fit inside a short run.

// File: rtl/sec_digit_flasher.sv
module sec_digit_flasher #(
  parameter int TICKS = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [6:0] seg_n
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic [3:0]    digit;
  logic          tick;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                digit <= 4'd0;
    else if (tick)          digit <= (digit == 4'd9) ? 4'd0 : digit + 4'd1;
  end

  always_comb begin
    case (digit)
      4'd0:    seg_n = 7'b1000000;
      4'd1:    seg_n = 7'b1111001;
      4'd2:    seg_n = 7'b0100100;
      4'd3:    seg_n = 7'b0110000;
      4'd4:    seg_n = 7'b0011001;
      4'd5:    seg_n = 7'b0010010;
      4'd6:    seg_n = 7'b0000010;
      4'd7:    seg_n = 7'b1111000;
      4'd8:    seg_n = 7'b0000000;
      4'd9:    seg_n = 7'b0010000;
      default: seg_n = 7'b1111111;
    endcase
  end
endmodule

// File: rtl/sec_digit_flasher_chk.sv
module sec_digit_flasher_chk #(
  parameter int TICKS = 50_000_000
) (
  input logic                                    clk,
  input logic                                    rst,
  input logic [((TICKS > 1) ? $clog2(TICKS) : 1)-1:0] cnt,
  input logic [3:0]                              digit,
  input logic                                    tick
);
  int gap;

  always_ff @(posedge clk) begin
    if (rst || tick) gap <= 0;
    else             gap <= gap + 1;
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst) digit <= 4'd9);                     // R8
  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst) int'(cnt) <= TICKS - 1);         // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(digit));                 // R3
  AST_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && digit != 4'd9) |=> digit == $past(digit) + 4'd1);                                            // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (rst) (tick && digit == 4'd9) |=> digit == 4'd0); // R5
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst) tick |-> gap == TICKS - 1);        // R3
endmodule

bind sec_digit_flasher sec_digit_flasher_chk #(.TICKS(TICKS)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .digit(digit), .tick(tick)
);

// File: tb/sim_sec_digit_flasher.sv
module sim_sec_digit_flasher;
  localparam int T = 5;
  localparam logic [6:0] SEG [10] = '{7'b1000000, 7'b1111001, 7'b0100100, 7'b0110000, 7'b0011001,
                                      7'b0010010, 7'b0000010, 7'b1111000, 7'b0000000, 7'b0010000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] seg_n;
  int errors = 0;
  int checks = 0;

  sec_digit_flasher #(.TICKS(T)) u0 (.clk(clk), .rst(rst), .seg_n(seg_n));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 reset shows 0", seg_n, 7'b1000000);
    step();
    chk("R1 reset held", seg_n, SEG[0]);
    rst = 1'b0;

    for (int k = 1; k <= 20 * T + 3; k++) begin
      step();
      if (k < T)                 chk("R2 first hold", seg_n, SEG[0]);
      else if ((k / T) % 10 == 0) chk("R5 wrap to 0", seg_n, SEG[0]);
      else                       chk("R3 R4 R6 sequence", seg_n, SEG[(k / T) % 10]);
    end

    chk("R6 digit 1 code", SEG[1], 7'b1111001);

    while (seg_n !== SEG[6]) step();
    rst = 1'b1;
    step();
    chk("R7 mid reset", seg_n, SEG[0]);
    step();
    rst = 1'b0;
    for (int k = 1; k < T; k++) begin
      step();
      chk("R7 full hold after reset", seg_n, SEG[0]);
    end
    step();
    chk("R7 first step after reset", seg_n, SEG[1]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule